// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) handles conflicts between instructions in flight. It compares the source register numbers of the instruction in decode with the destination register numbers of the two instructions ahead of it. From that comparison it produces the operand bypass selects for the execute stage, a freeze signal for the fetch side, and bubble-insertion signals.

The bypass selects are computed one stage early, while the consumer is still in decode, and are registered. They are therefore ready at the start of the consumer's execute cycle. Freeze and flush are combinational, because they must act in the same cycle. A load directly followed by a consumer of its result costs one frozen cycle. Branches are resolved in decode, and fetch proceeds as if every branch is not taken. When a branch resolves taken, the one wrongly fetched instruction is discarded.

Top module: `hzd_ctrl`

## Requirements
- R1: When the instruction one ahead of the consumer writes a nonzero register that an operand uses, that operand's select in the consumer's execute cycle is 1 (take the value held after the execute stage).
- R2: When only the instruction two ahead matches and has its register-write enable set, the select is 2 (take the value held after the memory stage). A match without write enable gives 0 (register file).
- R3: When both older instructions write the same source register, the nearer one wins (select 1).
- R4: Register 0 never produces a nonzero select, and a load to register 0 never causes a freeze.
- R5: A load in execute whose destination is a used source of the decode instruction raises `stall` and `bubble_idex` for exactly one cycle. After that cycle the consumer's select for that operand is 2.
- R6: A matching source that the decode instruction does not use causes no freeze.
- R7: A taken branch in decode raises `kill_ifid` for one cycle when not frozen. A not-taken branch never raises it.
- R8: Freeze has priority over a taken branch: `kill_ifid` stays 0 while `stall` is 1.
- R9: After reset both selects are 0.
- R10: The selects seen in execute reflect the decode inputs of the previous cycle. The cycle after a freeze shows select 0 for the bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src_a | input | REG_W | First source register of the instruction in decode |
| dec_src_b | input | REG_W | Second source register of the instruction in decode |
| dec_use_a | input | 1 | First source is read |
| dec_use_b | input | 1 | Second source is read |
| dec_br_taken | input | 1 | Branch in decode resolved taken |
| ex_dst | input | REG_W | Destination of the instruction in execute |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_W | Destination of the instruction in the memory stage |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| stall | output | 1 | Freeze the PC and the fetch/decode register |
| kill_ifid | output | 1 | Turn the fetch/decode register into a bubble |
| bubble_idex | output | 1 | Zero the control bits entering execute |
| sel_a | output | 2 | Operand A select: 0 register file, 1 after-execute, 2 after-memory |
| sel_b | output | 2 | Operand B select, same encoding |

## Verification
The bench runs a stream of instructions through a behavioural pipeline of stage records and compares all five outputs each cycle. It targets the following cases:
- A register rewritten by both older instructions: a wrong priority forwards a stale value.
- Register 0 as a source and as a load destination: a missing zero check forwards or freezes spuriously.
- A load followed by a consumer that names the loaded register in an unused field: a design ignoring use flags loses a cycle.
- A taken branch that is itself waiting on a load: a design that flushes during the freeze discards the branch's successor twice.
- A two-ahead match with write enable off: a design that ignores the enable forwards a non-result.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'd0,
    SEL_EXOUT = 2'd1,
    SEL_MEMOUT = 2'd2
  } sel_e;
endpackage

// File: rtl/hzd_src_pick.sv
module hzd_src_pick
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  output sel_e             sel
);
  localparam logic [REG_W-1:0] ZERO = '0;

  logic live;
  logic hit_near;
  logic hit_far;
  sel_e nxt;

  assign live     = used && (src != ZERO);
  assign hit_near = live && ex_wr  && (ex_dst  == src);
  assign hit_far  = live && mem_wr && (mem_dst == src);

  always_comb begin
    if (hit_near)     nxt = SEL_EXOUT;
    else if (hit_far) nxt = SEL_MEMOUT;
    else              nxt = SEL_RF;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) sel <= SEL_RF;
    else             sel <= nxt;
  end

  AST_ZERO_NEVER_FWD: assert property (@(posedge clk) disable iff (rst)
    ($past(src) == ZERO) |-> (sel == SEL_RF)); // R4
  AST_HOLD_GIVES_RF: assert property (@(posedge clk) disable iff (rst)
    $past(hold) |-> (sel == SEL_RF)); // R10
  AST_NEAR_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($past(used && src != ZERO && ex_wr && ex_dst == src) && !$past(hold))
      |-> (sel == SEL_EXOUT)); // R3
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] src,
  input  logic [NSRC-1:0]            used,
  input  logic [REG_W-1:0]           ex_dst,
  input  logic                       ex_load,
  output logic                       freeze
);
  logic [NSRC-1:0] dep;

  for (genvar g = 0; g < NSRC; g++) begin : g_dep
    assign dep[g] = used[g] && (src[g] == ex_dst);
  end

  assign freeze = ex_load && (ex_dst != '0) && (|dep);
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             dec_use_a,
  input  logic             dec_use_b,
  input  logic             dec_br_taken,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  output logic             stall,
  output logic             kill_ifid,
  output logic             bubble_idex,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic [NSRC-1:0]            uses;
  sel_e                       sels [NSRC];
  logic                       freeze;

  assign srcs = {dec_src_b, dec_src_a};
  assign uses = {dec_use_b, dec_use_a};

  hzd_load_use #(.REG_W(REG_W), .NSRC(NSRC)) i_lu (
    .src(srcs), .used(uses), .ex_dst(ex_dst), .ex_load(ex_load),
    .freeze(freeze)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_pick
    hzd_src_pick #(.REG_W(REG_W)) i_pick (
      .clk(clk), .rst(rst), .hold(freeze),
      .src(srcs[g]), .used(uses[g]),
      .ex_dst(ex_dst), .ex_wr(ex_wr),
      .mem_dst(mem_dst), .mem_wr(mem_wr),
      .sel(sels[g])
    );
  end

  // Freeze outranks the branch: the branch stays in decode and resolves again.
  assign stall       = freeze;
  assign bubble_idex = freeze;
  assign kill_ifid   = dec_br_taken && !freeze;
  assign sel_a       = sels[0];
  assign sel_b       = sels[1];

  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ex_load && ex_dst != '0)); // R5
  AST_NO_KILL_WHEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !(kill_ifid && stall)); // R8
  AST_BUBBLE_WITH_STALL: assert property (@(posedge clk) disable iff (rst)
    bubble_idex == stall); // R5
  AST_SEL_RESET: assert property (@(posedge clk)
    $past(rst) |-> (sel_a == 2'd0 && sel_b == 2'd0)); // R9
endmodule

// File: tb/test_hzd_ctrl.sv
module test_hzd_ctrl;
  typedef struct packed {
    logic [4:0] rd, rs1, rs2;
    logic u1, u2, wr, ld, br;
  } ins_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] dec_src_a, dec_src_b, ex_dst, mem_dst;
  logic dec_use_a, dec_use_b, dec_br_taken, ex_wr, ex_load, mem_wr;
  logic stall, kill_ifid, bubble_idex;
  logic [1:0] sel_a, sel_b;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  hzd_ctrl #(.REG_W(5)) i_hzd_ctrl (
    .clk(clk), .rst(rst),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
    .dec_br_taken(dec_br_taken),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wr(mem_wr),
    .stall(stall), .kill_ifid(kill_ifid), .bubble_idex(bubble_idex),
    .sel_a(sel_a), .sel_b(sel_b)
  );

  ins_t prog [32];
  ins_t s_id, s_ex, s_mem, s_wb;
  localparam ins_t NOP = '0;

  function automatic ins_t mk(int rd, int a, int b, bit u1, bit u2,
                              bit wr, bit ld, bit br);
    ins_t t;
    t.rd = 5'(rd); t.rs1 = 5'(a); t.rs2 = 5'(b);
    t.u1 = u1; t.u2 = u2; t.wr = wr; t.ld = ld; t.br = br;
    return t;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_sel(logic [4:0] s, logic u);
    if (!u || s == 0) return 0;
    if (s_mem.wr && s_mem.rd == s) return 1;
    if (s_wb.wr && s_wb.rd == s) return 2;
    return 0;
  endfunction

  function automatic string sel_tag(logic [4:0] s, logic u, bit was_frozen);
    if (u && s != 0 && s_mem.wr && s_mem.rd == s && s_wb.wr && s_wb.rd == s)
      return "R3";
    if (exp_sel(s, u) == 1) return "R1";
    if (exp_sel(s, u) == 2) return "R2";
    if (u && s == 0) return "R4";
    if (was_frozen) return "R10";
    return "R2";
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : run
    int pc;
    bit exp_stall, exp_kill, prev_frozen;
    string stag;
    for (int i = 0; i < 32; i++) prog[i] = NOP;
    prog[0]  = mk(1, 2, 3, 1, 1, 1, 0, 0);
    prog[1]  = mk(4, 1, 5, 1, 1, 1, 0, 0);   // R1 on A
    prog[2]  = mk(6, 7, 1, 1, 1, 1, 0, 0);   // R2 on B
    prog[3]  = mk(1, 0, 0, 1, 1, 1, 0, 0);
    prog[4]  = mk(1, 2, 2, 1, 1, 1, 0, 0);
    prog[5]  = mk(8, 1, 1, 1, 1, 1, 0, 0);   // R3 both
    prog[6]  = mk(0, 2, 0, 1, 0, 1, 0, 0);
    prog[7]  = mk(9, 0, 0, 1, 1, 1, 0, 0);   // R4 source zero
    prog[8]  = mk(9, 2, 0, 1, 0, 1, 1, 0);   // load r9
    prog[9]  = mk(10, 9, 3, 1, 1, 1, 0, 0);  // R5 then R10
    prog[10] = mk(11, 2, 0, 1, 0, 1, 1, 0);
    prog[11] = mk(12, 3, 11, 1, 0, 1, 0, 0); // R6 unused match
    prog[12] = mk(13, 2, 3, 1, 1, 0, 0, 0);  // no write enable
    prog[13] = NOP;
    prog[14] = mk(15, 13, 13, 1, 1, 1, 0, 0);// R2 gated by enable
    prog[15] = mk(14, 2, 0, 1, 0, 1, 1, 0);
    prog[16] = mk(0, 14, 3, 1, 1, 0, 0, 1);  // R8 then R7
    prog[17] = mk(16, 2, 3, 1, 1, 1, 0, 0);  // discarded
    prog[18] = mk(0, 2, 3, 1, 1, 0, 0, 0);   // branch not taken
    prog[19] = mk(0, 2, 0, 1, 0, 1, 1, 0);   // load to r0
    prog[20] = mk(17, 0, 0, 1, 1, 1, 0, 0);  // R4 no freeze
    s_id = NOP; s_ex = NOP; s_mem = NOP; s_wb = NOP;
    pc = 0; prev_frozen = 0;
    dec_src_a = 0; dec_src_b = 0; dec_use_a = 0; dec_use_b = 0;
    dec_br_taken = 0; ex_dst = 0; ex_wr = 0; ex_load = 0;
    mem_dst = 0; mem_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", sel_a, 0, "sel_a in reset");
    check("R9", sel_b, 0, "sel_b in reset");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9", sel_a, 0, "sel_a after reset");
    check("R9", sel_b, 0, "sel_b after reset");
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      cycles++;
      dec_src_a = s_id.rs1; dec_src_b = s_id.rs2;
      dec_use_a = s_id.u1;  dec_use_b = s_id.u2;
      dec_br_taken = s_id.br;
      ex_dst = s_ex.rd; ex_wr = s_ex.wr; ex_load = s_ex.ld;
      mem_dst = s_mem.rd; mem_wr = s_mem.wr;
      #1;
      // Selects describe the instruction now in execute (R10).
      check(sel_tag(s_ex.rs1, s_ex.u1, prev_frozen), sel_a,
            exp_sel(s_ex.rs1, s_ex.u1), "sel_a");
      check(sel_tag(s_ex.rs2, s_ex.u2, prev_frozen), sel_b,
            exp_sel(s_ex.rs2, s_ex.u2), "sel_b");
      exp_stall = s_ex.ld && s_ex.rd != 0 &&
        ((s_id.u1 && s_id.rs1 == s_ex.rd) || (s_id.u2 && s_id.rs2 == s_ex.rd));
      exp_kill = s_id.br && !exp_stall;
      if (s_ex.ld && s_ex.rd == 0) stag = "R4";
      else if (s_ex.ld && !exp_stall &&
               (s_id.rs1 == s_ex.rd || s_id.rs2 == s_ex.rd)) stag = "R6";
      else stag = "R5";
      check(stag, stall, int'(exp_stall), "stall");
      check("R5", bubble_idex, int'(exp_stall), "bubble_idex");
      check((s_id.br && exp_stall) ? "R8" : "R7", kill_ifid,
            int'(exp_kill), "kill_ifid");
      // Advance the behavioural pipeline.
      s_wb = s_mem;
      s_mem = s_ex;
      if (exp_stall) begin
        s_ex = NOP;
      end else begin
        s_ex = s_id;
        if (exp_kill) begin
          s_id = NOP;
          pc++;
        end else begin
          s_id = (pc < 32) ? prog[pc] : NOP;
          pc++;
        end
      end
      prev_frozen = exp_stall;
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule